// File: doc/BRIEF.md
# Clustered Replicated Register File

This block holds the architectural integer registers of a wide in-order execution core whose lanes are split into clusters. Each cluster has a private copy of the register array, and only that cluster's operand reads use it, so each copy carries a fraction of the read ports a single shared array would need. Every result write is sent to all copies in the same clock cycle, so the copies never hold different values.

Each result port also carries the number of the cluster whose lane produced it. A read port sees a result from its own cluster in the cycle the result appears, as a zero-latency bypass. A result from another cluster reaches that read port one cycle later, through a one-cycle result stage. The copies themselves are written from that stage. A read picks, in falling priority: the youngest same-cluster result of the current cycle, then the youngest result of the previous cycle from any cluster, then the stored copy. Register 0 always reads as zero.

The defaults are four result ports, two clusters, 32 registers of 64 bits, and four read ports per cluster.

Top module: `crf_top`

## Requirements
- R1: After reset every register reads as zero on every read port of every cluster.
- R2: Register index 0 reads as zero on every port at all times, and writes aimed at it change nothing.
- R3: A result whose cluster field equals a reader's cluster appears on that reader's port in the same cycle it is presented (write-before-read inside a cluster).
- R4: A result whose cluster field names another cluster is not seen by a reader in its presentation cycle. It is seen from the following cycle onward.
- R5: When several enabled result ports name the same register in one cycle, the highest-numbered port's data is the one forwarded and the one stored.
- R6: A read returns the youngest same-cluster current-cycle result if there is one. Otherwise it returns the youngest previous-cycle result from any cluster. Otherwise it returns the stored copy.
- R7: Once two cycles pass with no enabled result port, every cluster reads the same value for every register.
- R8: Each cluster has 2N/K read ports, four by default. Each port reads its own address independently of the others in the same cycle. Read port j of cluster c occupies slice index c*(2N/K)+j of the flattened read buses.
- R9: A result port whose enable bit is low has no effect on any read, now or later.
- R10: Result port i occupies slice index i of the flattened write buses. Its cluster field is a binary cluster number, and a higher index means a younger result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all copies and the result stage |
| wr_en | input | NW | Enable per result port |
| wr_addr | input | NW*AW | Destination register per result port, flattened |
| wr_data | input | NW*DW | Result data per result port, flattened |
| wr_cid | input | NW*CW | Producing cluster per result port, flattened |
| rd_addr | input | NC*RP*AW | Source register per read port, all clusters, flattened |
| rd_data | output | NC*RP*DW | Operand data per read port, combinational, flattened |

## Verification
The bench builds the block with its defaults: four result ports, two clusters, 32 registers and 64-bit data. With these values every result port can collide with another on one register. Each cluster's reads can be served by all three priority levels in a single cycle. A cross-cluster result can be compared with an older same-register value still held in the stored copy. Random traffic is limited to registers 0 to 7, so collisions between ports and between the stage and a new result are frequent. The bench also makes writes to register 0 often and exercises all read ports of both clusters at once.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int DEF_NW   = 4;
    localparam int DEF_NC   = 2;
    localparam int DEF_NREG = 32;
    localparam int DEF_DW   = 64;

    // Where an operand read is served from
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_PREV  = 2'd2,
        SRC_FILE  = 2'd3
    } rd_src_e;

endpackage

// File: rtl/crf_wstage.sv
module crf_wstage #(
    parameter int NW = 4,
    parameter int AW = 5,
    parameter int DW = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW-1:0]    in_en,
    input  logic [NW*AW-1:0] in_addr,
    input  logic [NW*DW-1:0] in_data,
    output logic [NW-1:0]    st_en,
    output logic [NW*AW-1:0] st_addr,
    output logic [NW*DW-1:0] st_data
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_en <= '0;
        end else begin
            st_en <= in_en;
        end
    end

    always_ff @(posedge clk) begin
        st_addr <= in_addr;
        st_data <= in_data;
    end

endmodule

// File: rtl/crf_replica.sv
module crf_replica #(
    parameter int NW   = 4,
    parameter int NREG = 32,
    parameter int AW   = 5,
    parameter int DW   = 64,
    parameter int RP   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW-1:0]    w_en,
    input  logic [NW*AW-1:0] w_addr,
    input  logic [NW*DW-1:0] w_data,
    input  logic [RP*AW-1:0] r_addr,
    output logic [RP*DW-1:0] r_q
);

    logic [DW-1:0] mem [NREG];

    // Ascending port order: the highest-numbered port is applied last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else begin
            for (int p = 0; p < NW; p++) begin
                if (w_en[p] && (w_addr[p*AW +: AW] != '0)) begin
                    mem[w_addr[p*AW +: AW]] <= w_data[p*DW +: DW];
                end
            end
        end
    end

    generate
        for (genvar r = 0; r < RP; r++) begin : g_rd
            assign r_q[r*DW +: DW] = mem[r_addr[r*AW +: AW]];
        end
    endgenerate

endmodule

// File: rtl/crf_bypass.sv
module crf_bypass
    import crf_pkg::*;
#(
    parameter int NW  = 4,
    parameter int AW  = 5,
    parameter int CW  = 1,
    parameter int DW  = 64,
    parameter int CID = 0
) (
    input  logic [AW-1:0]    rd_addr,
    input  logic [NW-1:0]    cur_en,
    input  logic [NW*AW-1:0] cur_addr,
    input  logic [NW*DW-1:0] cur_data,
    input  logic [NW*CW-1:0] cur_cid,
    input  logic [NW-1:0]    st_en,
    input  logic [NW*AW-1:0] st_addr,
    input  logic [NW*DW-1:0] st_data,
    input  logic [DW-1:0]    file_q,
    output logic [DW-1:0]    rd_data
);

    logic          local_hit;
    logic [DW-1:0] local_val;
    logic          prev_hit;
    logic [DW-1:0] prev_val;
    rd_src_e       src;

    // Same-cluster results of this cycle, youngest port last
    always_comb begin
        local_hit = 1'b0;
        local_val = '0;
        for (int p = 0; p < NW; p++) begin
            if (cur_en[p] && (cur_cid[p*CW +: CW] == CW'(CID)) &&
                (cur_addr[p*AW +: AW] == rd_addr)) begin
                local_hit = 1'b1;
                local_val = cur_data[p*DW +: DW];
            end
        end
    end

    // All results of the previous cycle, youngest port last
    always_comb begin
        prev_hit = 1'b0;
        prev_val = '0;
        for (int p = 0; p < NW; p++) begin
            if (st_en[p] && (st_addr[p*AW +: AW] == rd_addr)) begin
                prev_hit = 1'b1;
                prev_val = st_data[p*DW +: DW];
            end
        end
    end

    always_comb begin
        if (rd_addr == '0) begin
            src = SRC_ZERO;
        end else if (local_hit) begin
            src = SRC_LOCAL;
        end else if (prev_hit) begin
            src = SRC_PREV;
        end else begin
            src = SRC_FILE;
        end
    end

    always_comb begin
        unique case (src)
            SRC_ZERO:  rd_data = '0;
            SRC_LOCAL: rd_data = local_val;
            SRC_PREV:  rd_data = prev_val;
            SRC_FILE:  rd_data = file_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/crf_top.sv
module crf_top
    import crf_pkg::*;
#(
    parameter int NW   = DEF_NW,
    parameter int NC   = DEF_NC,
    parameter int NREG = DEF_NREG,
    parameter int DW   = DEF_DW,
    localparam int AW    = $clog2(NREG),
    localparam int CW    = (NC > 1) ? $clog2(NC) : 1,
    localparam int LANES = NW / NC,
    localparam int RP    = 2 * LANES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NW-1:0]       wr_en,
    input  logic [NW*AW-1:0]    wr_addr,
    input  logic [NW*DW-1:0]    wr_data,
    input  logic [NW*CW-1:0]    wr_cid,
    input  logic [NC*RP*AW-1:0] rd_addr,
    output logic [NC*RP*DW-1:0] rd_data
);

    logic [NW-1:0]    st_en;
    logic [NW*AW-1:0] st_addr;
    logic [NW*DW-1:0] st_data;

    crf_wstage #(.NW(NW), .AW(AW), .DW(DW)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_en   (wr_en),
        .in_addr (wr_addr),
        .in_data (wr_data),
        .st_en   (st_en),
        .st_addr (st_addr),
        .st_data (st_data)
    );

    generate
        for (genvar c = 0; c < NC; c++) begin : g_cl
            logic [RP*DW-1:0] file_q;

            crf_replica #(
                .NW(NW), .NREG(NREG), .AW(AW), .DW(DW), .RP(RP)
            ) u_copy (
                .clk    (clk),
                .rst_n  (rst_n),
                .w_en   (st_en),
                .w_addr (st_addr),
                .w_data (st_data),
                .r_addr (rd_addr[c*RP*AW +: RP*AW]),
                .r_q    (file_q)
            );

            for (genvar j = 0; j < RP; j++) begin : g_port
                crf_bypass #(
                    .NW(NW), .AW(AW), .CW(CW), .DW(DW), .CID(c)
                ) u_byp (
                    .rd_addr  (rd_addr[(c*RP+j)*AW +: AW]),
                    .cur_en   (wr_en),
                    .cur_addr (wr_addr),
                    .cur_data (wr_data),
                    .cur_cid  (wr_cid),
                    .st_en    (st_en),
                    .st_addr  (st_addr),
                    .st_data  (st_data),
                    .file_q   (file_q[j*DW +: DW]),
                    .rd_data  (rd_data[(c*RP+j)*DW +: DW])
                );
            end
        end
    endgenerate

endmodule

// File: rtl/crf_chk.sv
module crf_chk #(
    parameter int NW   = 4,
    parameter int NC   = 2,
    parameter int NREG = 32,
    parameter int DW   = 64,
    localparam int AW  = $clog2(NREG),
    localparam int CW  = (NC > 1) ? $clog2(NC) : 1,
    localparam int RP  = 2 * (NW / NC)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NW-1:0]       wr_en,
    input logic [NW*AW-1:0]    wr_addr,
    input logic [NW*DW-1:0]    wr_data,
    input logic [NW*CW-1:0]    wr_cid,
    input logic [NC*RP*AW-1:0] rd_addr,
    input logic [NC*RP*DW-1:0] rd_data
);

    localparam int YP = NW - 1;

    generate
        for (genvar i = 0; i < NC*RP; i++) begin : g_zero
            // R2
            zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_addr[i*AW +: AW] == '0) |-> (rd_data[i*DW +: DW] == '0));
        end

        for (genvar c = 0; c < NC; c++) begin : g_cl
            // R3
            local_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en[YP] && (wr_cid[YP*CW +: CW] == CW'(c)) &&
                 (wr_addr[YP*AW +: AW] != '0) &&
                 (rd_addr[c*RP*AW +: AW] == wr_addr[YP*AW +: AW]))
                |-> (rd_data[c*RP*DW +: DW] == wr_data[YP*DW +: DW]));

            // R4
            late_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((wr_en == '0) && $past(wr_en[YP]) &&
                 ($past(wr_addr[YP*AW +: AW]) != '0) &&
                 (rd_addr[c*RP*AW +: AW] == $past(wr_addr[YP*AW +: AW])))
                |-> (rd_data[c*RP*DW +: DW] == $past(wr_data[YP*DW +: DW])));

            // R9
            quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((wr_en == '0) && ($past(wr_en) == '0) &&
                 $stable(rd_addr[c*RP*AW +: AW]))
                |-> $stable(rd_data[c*RP*DW +: DW]));
        end

        if (NC > 1) begin : g_sync
            // R7
            copies_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((wr_en == '0) && ($past(wr_en) == '0) &&
                 (rd_addr[0 +: AW] == rd_addr[RP*AW +: AW]))
                |-> (rd_data[0 +: DW] == rd_data[RP*DW +: DW]));
        end
    endgenerate

endmodule

bind crf_top crf_chk #(.NW(NW), .NC(NC), .NREG(NREG), .DW(DW)) u_chk (.*);

// File: tb/sim_crf_top.sv
module sim_crf_top;

    localparam int NW = 4, NC = 2, NREG = 32, DW = 64;
    localparam int AW = 5, CW = 1, RP = 4;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NW-1:0]       wr_en;
    logic [NW*AW-1:0]    wr_addr;
    logic [NW*DW-1:0]    wr_data;
    logic [NW*CW-1:0]    wr_cid;
    logic [NC*RP*AW-1:0] rd_addr;
    logic [NC*RP*DW-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural reference state
    logic [DW-1:0] m_reg [NREG];
    bit            st_v [NW];
    int            st_a [NW];
    logic [DW-1:0] st_d [NW];

    crf_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_cid(wr_cid), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] model_rd(int c, int a);
        logic [DW-1:0] v;
        bit hit;
        if (a == 0) return '0;
        hit = 0;
        v = m_reg[a];
        for (int p = 0; p < NW; p++)
            if (st_v[p] && st_a[p] == a) v = st_d[p];
        for (int p = 0; p < NW; p++)
            if (wr_en[p] && int'(wr_cid[p*CW +: CW]) == c && int'(wr_addr[p*AW +: AW]) == a) begin
                v = wr_data[p*DW +: DW];
                hit = 1;
            end
        return v;
    endfunction

    task automatic set_wr(int p, bit en, int a, logic [DW-1:0] d, int c);
        wr_en[p] = en;
        wr_addr[p*AW +: AW] = AW'(a);
        wr_data[p*DW +: DW] = d;
        wr_cid[p*CW +: CW] = CW'(c);
    endtask

    task automatic set_rd(int c, int p, int a);
        rd_addr[(c*RP+p)*AW +: AW] = AW'(a);
    endtask

    function automatic logic [DW-1:0] get_rd(int c, int p);
        return rd_data[(c*RP+p)*DW +: DW];
    endfunction

    task automatic chk(int c, int p, logic [DW-1:0] exp, string tag);
        logic [DW-1:0] got;
        got = get_rd(c, p);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cluster %0d port %0d: got %h expected %h", tag, c, p, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = '0;
    endtask

    // compare every read port to the model, then advance one clock
    task automatic tick(string tag);
        #4;
        for (int c = 0; c < NC; c++)
            for (int p = 0; p < RP; p++)
                chk(c, p, model_rd(c, int'(rd_addr[(c*RP+p)*AW +: AW])), tag);
        @(posedge clk);
        for (int p = 0; p < NW; p++)
            if (st_v[p] && st_a[p] != 0) m_reg[st_a[p]] = st_d[p];
        for (int p = 0; p < NW; p++) begin
            st_v[p] = wr_en[p];
            st_a[p] = int'(wr_addr[p*AW +: AW]);
            st_d[p] = wr_data[p*DW +: DW];
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) m_reg[i] = '0;
        for (int p = 0; p < NW; p++) begin st_v[p] = 0; st_a[p] = 0; st_d[p] = '0; end
        rst_n = 1'b0; wr_en = '0; wr_addr = '0; wr_data = '0; wr_cid = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents are zero
        for (int c = 0; c < NC; c++)
            for (int p = 0; p < RP; p++) set_rd(c, p, p + 1 + 4*c);
        #1;
        for (int c = 0; c < NC; c++)
            for (int p = 0; p < RP; p++) chk(c, p, '0, "R1");
        tick("R1");

        // R3 and R4: write r5 from cluster 0 on port 1
        set_wr(1, 1, 5, 64'hA5A5_0000_1111_2222, 0);
        set_rd(0, 0, 5); set_rd(1, 0, 5);
        #1;
        chk(0, 0, 64'hA5A5_0000_1111_2222, "R3");
        chk(1, 0, '0, "R4");
        tick("R3");
        idle(); set_rd(1, 0, 5); set_rd(0, 2, 5);
        #1;
        chk(1, 0, 64'hA5A5_0000_1111_2222, "R4");
        chk(0, 2, 64'hA5A5_0000_1111_2222, "R3");
        tick("R4");

        // R5 and R10: ports 0 and 2 both target r7, port 2 is younger
        set_wr(0, 1, 7, 64'h1, 1); set_wr(2, 1, 7, 64'h2222, 1);
        set_rd(1, 1, 7);
        #1; chk(1, 1, 64'h2222, "R5");
        tick("R5");
        idle(); tick("R5"); tick("R5");
        set_rd(0, 3, 7); set_rd(1, 3, 7);
        #1; chk(0, 3, 64'h2222, "R5"); chk(1, 3, 64'h2222, "R10");
        tick("R5");

        // R2: writes to r0 are dropped
        set_wr(3, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
        set_rd(0, 0, 0);
        #1; chk(0, 0, '0, "R2");
        tick("R2"); idle(); tick("R2");
        set_rd(1, 2, 0);
        #1; chk(1, 2, '0, "R2");
        tick("R2");

        // R6: stored S, then previous-cycle P from cluster 1, then local Q in cluster 0
        set_wr(0, 1, 9, 64'h5, 0); tick("R6"); idle(); tick("R6"); tick("R6");
        set_wr(0, 1, 9, 64'h50, 1); set_rd(0, 1, 9); set_rd(1, 1, 9);
        #1; chk(0, 1, 64'h5, "R6"); chk(1, 1, 64'h50, "R6");
        tick("R6");
        idle(); set_wr(1, 1, 9, 64'h500, 0);
        #1; chk(0, 1, 64'h500, "R6"); chk(1, 1, 64'h50, "R6");
        tick("R6");
        idle();
        #1; chk(0, 1, 64'h500, "R6"); chk(1, 1, 64'h500, "R6");
        tick("R6");

        // R9: disabled port has no effect
        set_wr(2, 0, 11, 64'hDEAD, 0); set_rd(0, 2, 11);
        #1; chk(0, 2, '0, "R9");
        tick("R9"); idle(); tick("R9"); tick("R9");
        set_rd(1, 2, 11);
        #1; chk(0, 2, '0, "R9"); chk(1, 2, '0, "R9");
        tick("R9");

        // R8: four independent reads in one cluster
        for (int p = 0; p < NW; p++) set_wr(p, 1, 12 + p, DW'(64'h100 + p), p / 2);
        tick("R8"); idle(); tick("R8"); tick("R8");
        for (int p = 0; p < RP; p++) set_rd(1, p, 15 - p);
        #1;
        for (int p = 0; p < RP; p++) chk(1, p, DW'(64'h100 + 3 - p), "R8");
        tick("R8");

        // random traffic on a narrow register window
        for (int n = 0; n < 600; n++) begin
            for (int p = 0; p < NW; p++)
                set_wr(p, bit'($urandom % 2), int'($urandom % 8), {$urandom, $urandom}, int'($urandom % NC));
            for (int c = 0; c < NC; c++)
                for (int p = 0; p < RP; p++) set_rd(c, p, int'($urandom % 8));
            tick("R6");
        end

        // R7: after two quiet cycles both copies agree on every register
        idle(); tick("R7"); tick("R7");
        for (int r = 0; r < NREG; r++) begin
            set_rd(0, 0, r); set_rd(1, 0, r);
            #1; chk(1, 0, get_rd(0, 0), "R7");
            tick("R7");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule